// File: doc/BRIEF.md
# Channel Interrupt and Data-Transfer Request Controller

This block gathers service requests that a channel microengine raises for each of its channels. It presents them as per-channel interrupt lines toward a host CPU and as per-channel data-transfer request lines toward a DMA engine. Every channel has two request kinds. Each kind has its own sticky status flop and its own enable flop. A request line is driven whenever both flops are set. A data-transfer request can be retired in two ways: by the host, or by the DMA engine pulsing that channel's completion acknowledge.

The host reaches the state through a simple single-cycle register bus, and sees the same flops through two layouts. The per-type layout has four words: interrupt status, interrupt enable, transfer status and transfer enable. In each word, bit n belongs to channel n. The per-channel layout has one small word per channel. The block also keeps three sticky error flags: an illegal-instruction flag for each of two engines and a signature-mismatch flag. It drives a global exception line from them.

Reads pass through a two-state access machine. `ACC_IDLE` waits for a request. On a read request it moves to `ACC_READ` (transition *read issue*), and read data is presented with a valid strobe for that cycle. If another read follows, the machine stays in `ACC_READ` (*read chain*). Otherwise it returns to `ACC_IDLE` (*read done*). A write, or no request at all, leaves `ACC_IDLE` unchanged (*idle hold*).

Top module: `chirq_dma_ctrl`

## Requirements
- R1: After reset every status, enable and exception flag is 0, `irq_out`, `dma_req`, `exc_irq` and `bus_rvalid` are low, and all four per-type words read 0.
- R2: A one-cycle pulse on `int_set[n]` or `dtr_set[n]` sets that channel's status bit at the next clock edge. A host write never sets a status bit.
- R3: `irq_out[n]` is high exactly when interrupt status n and interrupt enable n are both 1, and `dma_req[n]` is high exactly when transfer status n and transfer enable n are both 1.
- R4: Status bits are write-1-to-clear through the per-type status words: word 0x00 for interrupts and word 0x02 for transfers, bit n = channel n. Writing 0 leaves a bit unchanged. Words 0x01 and 0x03 hold the interrupt and transfer enables and are plain read/write.
- R5: When a set pulse and a clear from any source hit the same status bit in the same cycle, the bit ends up set.
- R6: A pulse on `dma_ack[n]` clears transfer status n at the next edge and has no effect on interrupt status n.
- R7: Channel n has its own word at address 0x40+n. Bit 0 is interrupt enable and bit 1 is transfer enable; both are read/write. Bit 2 is interrupt status and bit 3 is transfer status; both are write-1-to-clear. All other bits read 0.
- R8: The per-channel words and the per-type words map onto the same flops. A change made through either layout is visible through the other at the next read.
- R9: While `mod_dis` is high, set pulses are ignored, and host clears and DMA acknowledges still clear status bits.
- R10: Word 0x04 holds three sticky exception flags: bit 0 is the engine A illegal instruction (`exc_ill_a`), bit 1 is the engine B illegal instruction (`exc_ill_b`) and bit 2 is the signature mismatch (`exc_sig`). Each flag is write-1-to-clear, and a set pulse wins over a clear in the same cycle. `exc_irq` is the OR of the three flags.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request, and `bus_rvalid` is low otherwise. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_dis | input | 1 | Module disable; blocks set pulses |
| int_set | input | N_CH | Interrupt request set pulses from the engine |
| dtr_set | input | N_CH | Data-transfer request set pulses from the engine |
| dma_ack | input | N_CH | DMA completion acknowledges, one per channel |
| exc_ill_a | input | 1 | Illegal-instruction pulse, engine A |
| exc_ill_b | input | 1 | Illegal-instruction pulse, engine B |
| exc_sig | input | 1 | Signature-mismatch pulse |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | N_CH | Per-channel host interrupt lines |
| dma_req | output | N_CH | Per-channel data-transfer request lines |
| exc_irq | output | 1 | Global exception interrupt |

## Verification
The bench drives a set pulse into a status bit in the same cycle as a host clear, and in another case in the same cycle as a DMA acknowledge. A design that let the clear win would drop a request. Enables are written through one layout and read back through the other. A design that kept separate copies of the flops would read back stale bits. Exercising the bit order of the per-channel word catches swapped fields. While the module is disabled, the bench checks both that clears still work and that set pulses have no effect. The bench also writes all ones into the status words and into an unmapped address. A design that treated those writes as sets, or decoded the address loosely, would show status or enable bits that should still be zero.

// File: rtl/chirq_pkg.sv
package chirq_pkg;
    // Per-type word addresses (bit n = channel n)
    localparam int A_INT_STS = 'h00;
    localparam int A_INT_EN  = 'h01;
    localparam int A_DTR_STS = 'h02;
    localparam int A_DTR_EN  = 'h03;
    localparam int A_EXC     = 'h04;
    // First per-channel word
    localparam int A_CH_BASE = 'h40;

    // Bit positions inside a per-channel word
    localparam int CW_IEN  = 0;
    localparam int CW_DEN  = 1;
    localparam int CW_ISTS = 2;
    localparam int CW_DSTS = 3;

    // Exception flag positions
    localparam int EX_ILL_A = 0;
    localparam int EX_ILL_B = 1;
    localparam int EX_SIG   = 2;
    localparam int EX_NUM   = 3;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_READ = 1'b1
    } acc_state_t;
endpackage

// File: rtl/chirq_req_bank.sv
module chirq_req_bank #(
    parameter int N_CH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic [N_CH-1:0] clr_i,
    input  logic [N_CH-1:0] en_we_i,
    input  logic [N_CH-1:0] en_val_i,
    output logic [N_CH-1:0] sts_o,
    output logic [N_CH-1:0] en_o,
    output logic [N_CH-1:0] req_o
);
    logic [N_CH-1:0] sts_q;
    logic [N_CH-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_i) | set_i;
            en_q  <= (en_q & ~en_we_i) | (en_val_i & en_we_i);
        end
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;
    assign req_o = sts_q & en_q;

    // R5: a set pulse always lands, whatever clears arrive with it
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(set_i)) == $past(set_i)));

    // R2: a status bit can rise only after a set pulse
    assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(set_i)) == '0));

    // R4: a clear without a set leaves the bit low
    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/chirq_exc_flags.sv
module chirq_exc_flags
    import chirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EX_NUM-1:0] src_i,
    input  logic [EX_NUM-1:0] clr_i,
    output logic [EX_NUM-1:0] flags_o,
    output logic              irq_o
);
    logic [EX_NUM-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | src_i;
    end

    assign flags_o = flags_q;
    assign irq_o   = |flags_q;

    // R10: a flag stays set until a host clear reaches it
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0));

    // R10: a source pulse always sets its flag
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(src_i)) == $past(src_i)));
endmodule

// File: rtl/chirq_regmap.sv
module chirq_regmap
    import chirq_pkg::*;
#(
    parameter int N_CH   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N_CH-1:0]   int_sts,
    input  logic [N_CH-1:0]   int_en,
    input  logic [N_CH-1:0]   dtr_sts,
    input  logic [N_CH-1:0]   dtr_en,
    input  logic [EX_NUM-1:0] exc_flags,
    output logic [N_CH-1:0]   host_int_clr,
    output logic [N_CH-1:0]   host_dtr_clr,
    output logic [N_CH-1:0]   int_en_we,
    output logic [N_CH-1:0]   int_en_val,
    output logic [N_CH-1:0]   dtr_en_we,
    output logic [N_CH-1:0]   dtr_en_val,
    output logic [EX_NUM-1:0] exc_clr,
    output logic [DATA_W-1:0] rd_word
);
    logic            wr_go;
    logic            hit_ist, hit_ien, hit_dst, hit_den, hit_exc;
    logic [N_CH-1:0] ch_hit;
    logic [N_CH-1:0] cw_wr;

    assign wr_go   = bus_sel & bus_we;
    assign hit_ist = (bus_addr == ADDR_W'(A_INT_STS));
    assign hit_ien = (bus_addr == ADDR_W'(A_INT_EN));
    assign hit_dst = (bus_addr == ADDR_W'(A_DTR_STS));
    assign hit_den = (bus_addr == ADDR_W'(A_DTR_EN));
    assign hit_exc = (bus_addr == ADDR_W'(A_EXC));

    for (genvar g = 0; g < N_CH; g++) begin : g_ch_dec
        assign ch_hit[g] = (bus_addr == ADDR_W'(A_CH_BASE + g));
    end

    assign cw_wr = {N_CH{wr_go}} & ch_hit;

    always_comb begin
        host_int_clr = ((wr_go && hit_ist) ? bus_wdata[N_CH-1:0] : '0)
                     | (cw_wr & {N_CH{bus_wdata[CW_ISTS]}});
        host_dtr_clr = ((wr_go && hit_dst) ? bus_wdata[N_CH-1:0] : '0)
                     | (cw_wr & {N_CH{bus_wdata[CW_DSTS]}});
        int_en_we    = ((wr_go && hit_ien) ? {N_CH{1'b1}} : '0) | cw_wr;
        dtr_en_we    = ((wr_go && hit_den) ? {N_CH{1'b1}} : '0) | cw_wr;
        int_en_val   = hit_ien ? bus_wdata[N_CH-1:0] : {N_CH{bus_wdata[CW_IEN]}};
        dtr_en_val   = hit_den ? bus_wdata[N_CH-1:0] : {N_CH{bus_wdata[CW_DEN]}};
        exc_clr      = (wr_go && hit_exc) ? bus_wdata[EX_NUM-1:0] : '0;
    end

    always_comb begin
        rd_word = '0;
        if (hit_ist) rd_word = DATA_W'(int_sts);
        if (hit_ien) rd_word = DATA_W'(int_en);
        if (hit_dst) rd_word = DATA_W'(dtr_sts);
        if (hit_den) rd_word = DATA_W'(dtr_en);
        if (hit_exc) rd_word = DATA_W'(exc_flags);
        for (int i = 0; i < N_CH; i++) begin
            if (ch_hit[i]) rd_word = DATA_W'({dtr_sts[i], int_sts[i], dtr_en[i], int_en[i]});
        end
    end
endmodule

// File: rtl/chirq_dma_ctrl.sv
module chirq_dma_ctrl
    import chirq_pkg::*;
#(
    parameter int N_CH   = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_dis,
    input  logic [N_CH-1:0]   int_set,
    input  logic [N_CH-1:0]   dtr_set,
    input  logic [N_CH-1:0]   dma_ack,
    input  logic              exc_ill_a,
    input  logic              exc_ill_b,
    input  logic              exc_sig,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [N_CH-1:0]   irq_out,
    output logic [N_CH-1:0]   dma_req,
    output logic              exc_irq
);
    logic [N_CH-1:0]   int_set_eff, dtr_set_eff;
    logic [N_CH-1:0]   int_sts, int_en, dtr_sts, dtr_en;
    logic [N_CH-1:0]   host_int_clr, host_dtr_clr;
    logic [N_CH-1:0]   int_en_we, int_en_val, dtr_en_we, dtr_en_val;
    logic [EX_NUM-1:0] exc_src, exc_clr, exc_flags;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_go;
    acc_state_t        state_q, state_d;

    // Engine set pulses are dropped while disabled; clears are not gated
    assign int_set_eff = mod_dis ? '0 : int_set;
    assign dtr_set_eff = mod_dis ? '0 : dtr_set;

    assign exc_src[EX_ILL_A] = exc_ill_a;
    assign exc_src[EX_ILL_B] = exc_ill_b;
    assign exc_src[EX_SIG]   = exc_sig;

    chirq_regmap #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regmap (
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .int_sts      (int_sts),
        .int_en       (int_en),
        .dtr_sts      (dtr_sts),
        .dtr_en       (dtr_en),
        .exc_flags    (exc_flags),
        .host_int_clr (host_int_clr),
        .host_dtr_clr (host_dtr_clr),
        .int_en_we    (int_en_we),
        .int_en_val   (int_en_val),
        .dtr_en_we    (dtr_en_we),
        .dtr_en_val   (dtr_en_val),
        .exc_clr      (exc_clr),
        .rd_word      (rd_word)
    );

    chirq_req_bank #(.N_CH(N_CH)) u_int_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (int_set_eff),
        .clr_i    (host_int_clr),
        .en_we_i  (int_en_we),
        .en_val_i (int_en_val),
        .sts_o    (int_sts),
        .en_o     (int_en),
        .req_o    (irq_out)
    );

    chirq_req_bank #(.N_CH(N_CH)) u_dtr_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (dtr_set_eff),
        .clr_i    (host_dtr_clr | dma_ack),
        .en_we_i  (dtr_en_we),
        .en_val_i (dtr_en_val),
        .sts_o    (dtr_sts),
        .en_o     (dtr_en),
        .req_o    (dma_req)
    );

    chirq_exc_flags u_exc (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (exc_src),
        .clr_i   (exc_clr),
        .flags_o (exc_flags),
        .irq_o   (exc_irq)
    );

    // Host read access machine
    assign rd_go = bus_sel & ~bus_we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_go ? ACC_READ : ACC_IDLE;
            ACC_READ: state_d = rd_go ? ACC_READ : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_go) rdata_q <= rd_word;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == ACC_READ);

    // R11: valid read data only follows a read request
    assert_rvalid_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_we));

    // R9: while disabled, no status bit of either kind rises
    assert_disable_blocks_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mod_dis) |-> (((int_sts & ~$past(int_sts)) | (dtr_sts & ~$past(dtr_sts))) == '0));

    // R6: an acknowledge without a competing set retires the transfer request
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dtr_sts & $past(dma_ack) & ~$past(dtr_set_eff)) == '0));

    // R6: an acknowledge never touches interrupt status
    assert_ack_spares_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack != '0 && !bus_sel && int_set_eff == '0) |=> $stable(int_sts));
endmodule

// File: tb/test_chirq_dma_ctrl.sv
module test_chirq_dma_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NV         = 8;
    // Row: [10:6] channel, [5] int set, [4] dtr set, [3] int en, [2] dtr en,
    //      [1] expected irq, [0] expected dma request
    localparam logic [10:0] VEC [NV] = '{
        {5'd0,  6'b111111},
        {5'd1,  6'b101110},
        {5'd2,  6'b011101},
        {5'd4,  6'b110101},
        {5'd8,  6'b111010},
        {5'd15, 6'b110000},
        {5'd30, 6'b001100},
        {5'd31, 6'b111111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_dis = 1'b0;
    logic [31:0] int_set = '0, dtr_set = '0, dma_ack = '0;
    logic        exc_ill_a = 1'b0, exc_ill_b = 1'b0, exc_sig = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] irq_out, dma_req;
    logic        exc_irq;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    chirq_dma_ctrl i_chirq_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .mod_dis(mod_dis),
        .int_set(int_set), .dtr_set(dtr_set), .dma_ack(dma_ack),
        .exc_ill_a(exc_ill_a), .exc_ill_b(exc_ill_b), .exc_sig(exc_sig),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_out(irq_out), .dma_req(dma_req), .exc_irq(exc_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        chk("R11 rvalid during read", {31'd0, bus_rvalid}, 32'd1);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] si, input logic [31:0] sd);
        @(negedge clk);
        int_set = si; dtr_set = sd;
        @(negedge clk);
        int_set = '0; dtr_set = '0;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp=done", WD_CYCLES);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", irq_out, 32'd0);
        chk("R1 dma_req", dma_req, 32'd0);
        chk("R1 exc_irq", {31'd0, exc_irq}, 32'd0);
        chk("R11 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(7'(a), rv);
            chk("R1 per-type word", rv, 32'd0);
        end

        // R2: host writes of ones never set status
        wr(7'h00, 32'hFFFF_FFFF);
        wr(7'h02, 32'hFFFF_FFFF);
        rd(7'h00, rv); chk("R2 int sts not host-set", rv, 32'd0);
        rd(7'h02, rv); chk("R2 dtr sts not host-set", rv, 32'd0);

        // R3/R7: vector table
        for (int k = 0; k < NV; k++) begin
            logic [4:0] ch;
            ch = VEC[k][10:6];
            wr(7'h40 + 7'(ch), {30'd0, VEC[k][2], VEC[k][3]});
            pulse(32'(VEC[k][5]) << ch, 32'(VEC[k][4]) << ch);
            chk("R3 irq_out vector", irq_out, 32'(VEC[k][1]) << ch);
            chk("R3 dma_req vector", dma_req, 32'(VEC[k][0]) << ch);
            rd(7'h40 + 7'(ch), rv);
            chk("R7 channel word layout", rv, {28'd0, VEC[k][4], VEC[k][5], VEC[k][2], VEC[k][3]});
            wr(7'h40 + 7'(ch), 32'h0000_000C);
            rd(7'h40 + 7'(ch), rv);
            chk("R7 channel word cleared", rv, 32'd0);
        end

        // R4: write-1-to-clear through per-type status word, zeros ignored
        pulse(32'h0000_0028, 32'd0);
        wr(7'h00, 32'd0);
        rd(7'h00, rv); chk("R4 write 0 keeps", rv, 32'h0000_0028);
        wr(7'h00, 32'h0000_0008);
        rd(7'h00, rv); chk("R4 write 1 clears", rv, 32'h0000_0020);
        wr(7'h00, 32'h0000_0020);

        // R5: set and host clear in the same cycle
        @(negedge clk);
        int_set = 32'h0000_0080;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'h00; bus_wdata = 32'h0000_0080;
        @(negedge clk);
        int_set = '0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(7'h00, rv); chk("R5 set beats host clear", rv, 32'h0000_0080);
        wr(7'h00, 32'h0000_0080);

        // R6: DMA acknowledge clears transfer only
        wr(7'h03, 32'h0000_0200);
        pulse(32'h0000_0200, 32'h0000_0200);
        chk("R6 dma_req before ack", dma_req, 32'h0000_0200);
        @(negedge clk); dma_ack = 32'h0000_0200;
        @(negedge clk); dma_ack = '0;
        chk("R6 dma_req after ack", dma_req, 32'd0);
        rd(7'h49, rv); chk("R6 int sts kept, dtr cleared", rv, 32'h0000_0006);
        // R5 with acknowledge competing
        @(negedge clk); dma_ack = 32'h0000_0200; dtr_set = 32'h0000_0200;
        @(negedge clk); dma_ack = '0; dtr_set = '0;
        chk("R5 set beats ack", dma_req, 32'h0000_0200);
        wr(7'h49, 32'h0000_000C);
        wr(7'h03, 32'd0);

        // R8: cross-view visibility
        wr(7'h01, 32'h0000_1000);
        rd(7'h4C, rv); chk("R8 type-write seen per-channel", rv, 32'h0000_0001);
        pulse(32'h0000_1000, 32'd0);
        chk("R3 irq via type enable", irq_out, 32'h0000_1000);
        wr(7'h4C, 32'h0000_0006);
        rd(7'h00, rv); chk("R8 channel clear seen per-type", rv, 32'd0);
        rd(7'h03, rv); chk("R8 channel enable seen per-type", rv, 32'h0000_1000);
        wr(7'h4C, 32'd0);

        // R9: module disable
        pulse(32'h0000_0004, 32'h0000_0004);
        mod_dis = 1'b1;
        pulse(32'h0000_0010, 32'h0000_0010);
        rd(7'h00, rv); chk("R9 int set ignored when disabled", rv, 32'h0000_0004);
        rd(7'h02, rv); chk("R9 dtr set ignored when disabled", rv, 32'h0000_0004);
        wr(7'h00, 32'h0000_0004);
        @(negedge clk); dma_ack = 32'h0000_0004;
        @(negedge clk); dma_ack = '0;
        rd(7'h00, rv); chk("R9 host clear while disabled", rv, 32'd0);
        rd(7'h02, rv); chk("R9 ack clear while disabled", rv, 32'd0);
        mod_dis = 1'b0;

        // R10: exception flags
        @(negedge clk); exc_ill_a = 1'b1;
        @(negedge clk); exc_ill_a = 1'b0;
        chk("R10 exc_irq on ill A", {31'd0, exc_irq}, 32'd1);
        @(negedge clk); exc_sig = 1'b1;
        @(negedge clk); exc_sig = 1'b0;
        rd(7'h04, rv); chk("R10 flags A+sig", rv, 32'h0000_0005);
        wr(7'h04, 32'h0000_0001);
        chk("R10 exc_irq stays with sig", {31'd0, exc_irq}, 32'd1);
        wr(7'h04, 32'h0000_0004);
        chk("R10 exc_irq low after clears", {31'd0, exc_irq}, 32'd0);
        @(negedge clk);
        exc_ill_b = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 7'h04; bus_wdata = 32'h0000_0002;
        @(negedge clk);
        exc_ill_b = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(7'h04, rv); chk("R10 set beats clear on ill B", rv, 32'h0000_0002);
        wr(7'h04, 32'h0000_0002);

        // R11: unmapped space
        wr(7'h10, 32'hFFFF_FFFF);
        rd(7'h01, rv); chk("R11 unmapped write leaves int en", rv, 32'd0);
        rd(7'h03, rv); chk("R11 unmapped write leaves dtr en", rv, 32'd0);
        rd(7'h10, rv); chk("R11 unmapped read", rv, 32'd0);
        rd(7'h60, rv); chk("R11 beyond last channel", rv, 32'd0);
        @(negedge clk);
        chk("R11 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

        finish_run();
    end
endmodule